// File: doc/BRIEF.md
# BCD Time-of-Day and Day Counter

This block keeps wall-clock time for a chip that already produces a one-pulse-per-second tick. Seconds and minutes run 00 to 59 and hours 00 to 23, all held as packed BCD bytes. The hour wrap from 23 to 00 advances a flat 15-bit binary day count. An alarm comparator watches minute, hour and day, and each of those fields has its own enable. A matching alarm latches a flag, and when the interrupt enable is set the flag drives a level interrupt.

Software reaches the block through a byte-wide register port. Writes take effect at the next clock edge. Reads are combinational from the address. The time, day and alarm fields can be loaded directly. A control register gathers the calendar run enable, the three alarm field enables, the interrupt enable, the write-one-to-clear alarm flag and a read-only busy bit. The busy bit marks the single cycle in which an accepted tick ripples through the counters.

Top module: `tod_day_counter`

## Requirements
- R1: After reset every time, day and alarm byte and every control bit read 0, and alarm_irq is 0.
- R2: The seconds register (address 0) counts 00 to 59 in packed BCD (tens in bits 7:4, units in bits 3:0) and wraps to 00. The wrap from 59 carries one into the minutes register (address 1).
- R3: Minutes count 00 to 59 in BCD and carry into the hour register (address 2). Hours count 00 to 23 in BCD.
- R4: The day count is binary and 15 bits wide. It increments when hours wrap from 23 to 00, and wraps from 0x7FFF to 0. Address 3 holds day bits 7:0. Address 4 holds day bits 14:8 in its bits 6:0, and its bit 7 reads 0.
- R5: A tick is accepted only when calendar enable (control register, address 9, bit 0) is 1. A tick while that bit is 0 leaves every counter unchanged.
- R6: The control bit 7 (busy) reads 1 in exactly the clock cycle after an accepted tick. The counters still show the old time in that cycle and show the advanced time from the next cycle. Ticks on consecutive cycles advance the time once per tick.
- R7: A write to any time, day or alarm register loads that field. If the write lands in the busy cycle, the written field takes the written value, and the other fields still advance with the carries computed from the old time.
- R8: Alarm match requires at least one enabled field. The minute enable is control bit 3 and compares against address 5. The hour enable is bit 4 and compares against address 6. The day enable is bit 5 and compares the zero-extended day against the 16-bit value {address 8, address 7}. The flag (bit 2) sets one cycle after the enabled fields begin to match. A disabled field or a mismatching enabled field prevents the flag.
- R9: Writing 1 to control bit 2 clears the flag, and writing 0 leaves it unchanged. The flag does not set again while the match persists. A set and a clear in the same cycle leave the flag at 1.
- R10: alarm_irq is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1. A control write ignores bit 7 and bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle pulse, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Two pairs of functions can fall in the same cycle, and each pair is provoked on purpose. In the first, a write to the seconds register is placed in the busy cycle of a tick that rolls 59 seconds into the next minute. The bench then expects the written seconds and the incremented minute. In the second, a write-one clear of the alarm flag is issued in the cycle in which the match first appears. The flag must read 1 afterwards, and a second clear must then hold it at 0 while the match persists. Around these cases, a sweep of several thousand ticks across the midnight and day-count wrap compares every field against an arithmetic model.

// File: rtl/tod_pkg.sv
package tod_pkg;
    parameter int BYTE_W = 8;
    parameter int DAY_W  = 15;
    parameter int ADDR_W = 4;
    parameter int NFIELD = 3;   // seconds, minutes, hours

    localparam int ADAY_W = 2 * BYTE_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC    = 4'd0,
        RA_MIN    = 4'd1,
        RA_HOUR   = 4'd2,
        RA_DAYLO  = 4'd3,
        RA_DAYHI  = 4'd4,
        RA_ALMIN  = 4'd5,
        RA_ALHOUR = 4'd6,
        RA_ALDLO  = 4'd7,
        RA_ALDHI  = 4'd8,
        RA_CTRL   = 4'd9
    } reg_addr_e;

    localparam int CB_BUSY = 7;
    localparam int CB_DEN  = 5;
    localparam int CB_HEN  = 4;
    localparam int CB_MEN  = 3;
    localparam int CB_FLAG = 2;
    localparam int CB_IE   = 1;
    localparam int CB_CEN  = 0;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hr;
        logic [DAY_W-1:0]  day;
        logic [BYTE_W-1:0] al_min;
        logic [BYTE_W-1:0] al_hr;
        logic [ADAY_W-1:0] al_day;
        logic              busy;
        logic              cal_en;
        logic              irq_en;
        logic              flag;
        logic              den;
        logic              hen;
        logic              men;
        logic              match_prev;
    } tod_state_t;
endpackage

// File: rtl/tod_bcd_step.sv
module tod_bcd_step #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    LIMIT = 8'h59
) (
    input  logic [W-1:0] cur,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         carry
);
    localparam int NW = W / 2;

    logic [NW-1:0] units;
    logic [NW-1:0] tens;

    assign units = cur[NW-1:0];
    assign tens  = cur[W-1:NW];
    assign carry = inc && (cur == LIMIT);

    always_comb begin
        nxt = cur;
        if (inc) begin
            if (cur == LIMIT) begin
                nxt = '0;
            end else if (units == NW'(9)) begin
                nxt = {tens + NW'(1), {NW{1'b0}}};
            end else begin
                nxt = {tens, units + NW'(1)};
            end
        end
    end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_pkg::*;
(
    input  logic [BYTE_W-1:0] min,
    input  logic [BYTE_W-1:0] hr,
    input  logic [DAY_W-1:0]  day,
    input  logic [BYTE_W-1:0] al_min,
    input  logic [BYTE_W-1:0] al_hr,
    input  logic [ADAY_W-1:0] al_day,
    input  logic              men,
    input  logic              hen,
    input  logic              den,
    output logic              match
);
    logic min_ok;
    logic hr_ok;
    logic day_ok;

    assign min_ok = !men || (min == al_min);
    assign hr_ok  = !hen || (hr == al_hr);
    assign day_ok = !den || (ADAY_W'(day) == al_day);
    assign match  = (men || hen || den) && min_ok && hr_ok && day_ok;
endmodule

// File: rtl/tod_day_counter.sv
module tod_day_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              alarm_irq
);
    localparam int DHI_W = DAY_W - BYTE_W;

    tod_state_t s_d;
    tod_state_t s_q;

    logic [NFIELD-1:0][BYTE_W-1:0] fld_cur;
    logic [NFIELD-1:0][BYTE_W-1:0] fld_nxt;
    logic [NFIELD:0]               fld_cy;
    logic [DAY_W-1:0]              day_nxt;
    logic                          match;
    logic                          set_evt;

    assign fld_cur[0] = s_q.sec;
    assign fld_cur[1] = s_q.min;
    assign fld_cur[2] = s_q.hr;
    assign fld_cy[0]  = s_q.busy;

    for (genvar g = 0; g < NFIELD; g++) begin : g_chain
        tod_bcd_step #(
            .W     (BYTE_W),
            .LIMIT ((g == NFIELD - 1) ? BYTE_W'(8'h23) : BYTE_W'(8'h59))
        ) u_step (
            .cur   (fld_cur[g]),
            .inc   (fld_cy[g]),
            .nxt   (fld_nxt[g]),
            .carry (fld_cy[g+1])
        );
    end

    assign day_nxt = s_q.day + DAY_W'(fld_cy[NFIELD]);

    tod_alarm_match u_alarm (
        .min    (s_q.min),
        .hr     (s_q.hr),
        .day    (s_q.day),
        .al_min (s_q.al_min),
        .al_hr  (s_q.al_hr),
        .al_day (s_q.al_day),
        .men    (s_q.men),
        .hen    (s_q.hen),
        .den    (s_q.den),
        .match  (match)
    );

    assign set_evt = match && !s_q.match_prev;

    always_comb begin
        s_d            = s_q;
        s_d.busy       = tick_sec && s_q.cal_en;
        s_d.match_prev = match;
        s_d.sec        = fld_nxt[0];
        s_d.min        = fld_nxt[1];
        s_d.hr         = fld_nxt[2];
        s_d.day        = day_nxt;
        if (reg_wr) begin
            case (reg_addr)
                RA_SEC:    s_d.sec = reg_wdata;
                RA_MIN:    s_d.min = reg_wdata;
                RA_HOUR:   s_d.hr  = reg_wdata;
                RA_DAYLO:  s_d.day[BYTE_W-1:0] = reg_wdata;
                RA_DAYHI:  s_d.day[DAY_W-1:BYTE_W] = reg_wdata[DHI_W-1:0];
                RA_ALMIN:  s_d.al_min = reg_wdata;
                RA_ALHOUR: s_d.al_hr  = reg_wdata;
                RA_ALDLO:  s_d.al_day[BYTE_W-1:0] = reg_wdata;
                RA_ALDHI:  s_d.al_day[ADAY_W-1:BYTE_W] = reg_wdata;
                RA_CTRL: begin
                    s_d.den    = reg_wdata[CB_DEN];
                    s_d.hen    = reg_wdata[CB_HEN];
                    s_d.men    = reg_wdata[CB_MEN];
                    s_d.irq_en = reg_wdata[CB_IE];
                    s_d.cal_en = reg_wdata[CB_CEN];
                    if (reg_wdata[CB_FLAG]) begin
                        s_d.flag = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (set_evt) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SEC:    reg_rdata = s_q.sec;
            RA_MIN:    reg_rdata = s_q.min;
            RA_HOUR:   reg_rdata = s_q.hr;
            RA_DAYLO:  reg_rdata = s_q.day[BYTE_W-1:0];
            RA_DAYHI:  reg_rdata = BYTE_W'(s_q.day[DAY_W-1:BYTE_W]);
            RA_ALMIN:  reg_rdata = s_q.al_min;
            RA_ALHOUR: reg_rdata = s_q.al_hr;
            RA_ALDLO:  reg_rdata = s_q.al_day[BYTE_W-1:0];
            RA_ALDHI:  reg_rdata = s_q.al_day[ADAY_W-1:BYTE_W];
            RA_CTRL: begin
                reg_rdata[CB_BUSY] = s_q.busy;
                reg_rdata[CB_DEN]  = s_q.den;
                reg_rdata[CB_HEN]  = s_q.hen;
                reg_rdata[CB_MEN]  = s_q.men;
                reg_rdata[CB_FLAG] = s_q.flag;
                reg_rdata[CB_IE]   = s_q.irq_en;
                reg_rdata[CB_CEN]  = s_q.cal_en;
            end
            default: ;
        endcase
    end

    assign alarm_irq = s_q.flag && s_q.irq_en;
endmodule

// File: rtl/tod_day_counter_chk.sv
module tod_day_counter_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_sec,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              alarm_irq,
    input logic              busy,
    input logic              cal_en,
    input logic              irq_en,
    input logic              flag,
    input logic              match,
    input logic              match_prev,
    input logic [BYTE_W-1:0] sec,
    input logic [BYTE_W-1:0] min,
    input logic [BYTE_W-1:0] hr,
    input logic [DAY_W-1:0]  day
);
    logic ctrl_clr;
    assign ctrl_clr = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CB_FLAG];

    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(reg_wr) && ($past(day) == {DAY_W{1'b1}}) &&
         ($past(hr) == 8'h23) && ($past(min) == 8'h59) && ($past(sec) == 8'h59))
        |-> (day == '0));

    p_no_tick_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cal_en)) |-> !busy);

    p_busy_from_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(tick_sec && cal_en));

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(reg_wr)) |->
        ($stable(sec) && $stable(min) && $stable(hr) && $stable(day)));

    p_flag_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(match && !match_prev));

    p_flag_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_clr) && !$past(match && !match_prev)) |-> !flag);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (irq_en && flag));
endmodule

bind tod_day_counter tod_day_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_sec   (tick_sec),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .alarm_irq  (alarm_irq),
    .busy       (s_q.busy),
    .cal_en     (s_q.cal_en),
    .irq_en     (s_q.irq_en),
    .flag       (s_q.flag),
    .match      (match),
    .match_prev (s_q.match_prev),
    .sec        (s_q.sec),
    .min        (s_q.min),
    .hr         (s_q.hr),
    .day        (s_q.day)
);

// File: tb/tod_day_counter_tb.sv
module tod_day_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tod_day_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sec  (tick_sec),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .alarm_irq (alarm_irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 4'(a);
        #2;
        d = int'(reg_rdata);
    endtask

    task automatic tick();
        @(negedge clk); tick_sec = 1'b1;
        @(negedge clk); tick_sec = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_time(input int h, input int m, input int s, input int d);
        wr(0, bcd(s)); wr(1, bcd(m)); wr(2, bcd(h));
        wr(3, d & 255); wr(4, (d >> 8) & 255);
    endtask

    task automatic chk_time(input string req, input int h, input int m, input int s, input int d);
        int v;
        rd(0, v); chk(req, v, bcd(s));
        rd(1, v); chk(req, v, bcd(m));
        rd(2, v); chk(req, v, bcd(h));
        rd(3, v); chk(req, v, d & 255);
        rd(4, v); chk(req, v, (d >> 8) & 127);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        int s, m, h, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(a, v); chk("R1 reset reg", v, 0);
        end
        chk("R1 reset irq", int'(alarm_irq), 0);

        // R5 tick ignored while disabled
        set_time(1, 2, 3, 4);
        tick();
        chk_time("R5 disabled tick", 1, 2, 3, 4);

        // R6 busy window and old/new values
        wr(9, 8'h01);
        @(negedge clk); tick_sec = 1'b1;
        @(negedge clk); tick_sec = 1'b0;
        rd(9, v); chk("R6 busy high", (v >> 7) & 1, 1);
        rd(0, v); chk("R6 old sec during busy", v, 8'h03);
        @(negedge clk);
        rd(9, v); chk("R6 busy low", (v >> 7) & 1, 0);
        rd(0, v); chk("R6 new sec", v, 8'h04);

        // R6 back-to-back ticks
        @(negedge clk); tick_sec = 1'b1;
        repeat (5) @(negedge clk);
        tick_sec = 1'b0;
        @(negedge clk);
        chk_time("R6 consecutive ticks", 1, 2, 9, 4);

        // R2 R3 R4 sweep across midnight and day wrap
        h = 23; m = 0; s = 0; d = 32767;
        set_time(h, m, s, d);
        for (int i = 0; i < 3700; i++) begin
            tick();
            s++;
            if (s == 60) begin s = 0; m++; end
            if (m == 60) begin m = 0; h++; end
            if (h == 24) begin h = 0; d = (d + 1) & 32767; end
            chk_time("R2 R3 R4 sweep", h, m, s, d);
        end

        // R4 day high byte layout, bit 7 ignored
        wr(4, 8'hFF);
        rd(4, v); chk("R4 day high bit7 reads 0", v, 8'h7F);

        // R7 write in busy cycle overrides seconds, minute still advances
        set_time(10, 5, 59, 9);
        @(negedge clk); tick_sec = 1'b1;
        @(negedge clk); tick_sec = 1'b0;
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h30;
        @(negedge clk); reg_wr = 1'b0;
        chk_time("R7 busy-cycle write", 10, 6, 30, 9);

        // R8 alarm minute/hour/day match
        set_time(0, 0, 58, 3);
        wr(5, 8'h01); wr(6, 8'h00); wr(7, 3); wr(8, 0);
        wr(9, 8'h3B);
        tick();
        rd(9, v); chk("R8 no early flag", (v >> 2) & 1, 0);
        tick();
        rd(9, v); chk("R8 flag on match", (v >> 2) & 1, 1);
        chk("R10 irq with ie", int'(alarm_irq), 1);
        wr(9, 8'h39);
        chk("R10 irq off without ie", int'(alarm_irq), 0);
        rd(9, v); chk("R9 write 0 keeps flag", (v >> 2) & 1, 1);
        rd(9, v); chk("R10 bit7 and bit6 ignored", v & 8'hC0, 0);
        wr(9, 8'hFF);
        rd(9, v); chk("R9 w1c clears", (v >> 2) & 1, 0);
        chk("R10 irq follows clear", int'(alarm_irq), 0);
        @(negedge clk);
        rd(9, v); chk("R9 no reset while matching", (v >> 2) & 1, 0);

        // R8 day mismatch blocks
        wr(9, 8'h07);
        set_time(0, 0, 59, 4);
        wr(9, 8'h3B);
        tick();
        rd(9, v); chk("R8 day mismatch", (v >> 2) & 1, 0);

        // R8 disabled day field allows match
        set_time(0, 0, 59, 4);
        wr(9, 8'h1B);
        tick();
        rd(9, v); chk("R8 day disabled", (v >> 2) & 1, 1);

        // R8 no enables -> no match
        wr(9, 8'h07);
        set_time(0, 0, 59, 3);
        wr(9, 8'h03);
        tick();
        rd(9, v); chk("R8 no enable no flag", (v >> 2) & 1, 0);

        // R9 set and clear in the same cycle: set wins
        wr(9, 8'h01);
        set_time(0, 0, 59, 3);
        wr(9, 8'h3B);
        @(negedge clk); tick_sec = 1'b1;
        @(negedge clk); tick_sec = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h3F;
        @(negedge clk); reg_wr = 1'b0;
        rd(9, v); chk("R9 set beats clear", (v >> 2) & 1, 1);
        wr(9, 8'h3F);
        rd(9, v); chk("R9 later clear", (v >> 2) & 1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule